// File: doc/BRIEF.md
# Shadowed-Read Seconds Clock

This block is a memory-mapped time-of-day counter clocked by a fast bus clock and advanced by a one-cycle enable that marks each edge of a slow 32 kHz reference. A slow-side timebase turns those ticks into milliseconds and whole seconds. It approximates one millisecond as a fixed tick count and adds one extra tick at a regular interval to correct the drift. Software never reads the running counters directly. Instead, a posting sequencer copies them to bus-visible registers at a fixed tick interval, and raises a busy flag for the duration of each copy.

Two seconds alarms and one millisecond alarm compare against the running counters. Each sets a sticky bit in an event status register that software clears by writing ones. An event mask gates those bits onto a single level interrupt. Reading the milliseconds register latches the visible seconds into a shadow register, so a following shadow read gives a seconds value that pairs with the milliseconds value just read. A write that lands during a copy is held in a one-entry slot and applied when the copy ends.

Top module: `rtc_shadow_timer`

## Requirements
- R1: The millisecond counter advances after TICKS_PER_MS ticks, or after TICKS_PER_MS+1 ticks for every CORR_PERIOD-th millisecond. It wraps from MS_PER_SEC-1 to 0, and the seconds counter increments at that wrap.
- R2: Every POST_TICKS ticks, bit 0 of the busy register (word offset 0x04) goes to 1 for BUSY_LEN clock cycles. The visible seconds (0x08) and milliseconds (0x10) take the running values when busy drops, and at no other time, except for a seconds write.
- R3: A read of the milliseconds register (0x10) loads the visible seconds into the shadow register (0x0C). Later writes to seconds do not change the shadow register until the next milliseconds read.
- R4: A write to 0x08 loads both the running seconds counter and the visible seconds with the written value.
- R5: Seconds alarm 0 (0x14, event bit 0) and seconds alarm 1 (0x18, event bit 1) each set their event bit when the seconds counter takes on a new value equal to their compare value. A compare value of 0 never fires.
- R6: The millisecond alarm (0x1C, event bit 2) sets its event bit when the millisecond counter steps to a value equal to its nonzero compare value.
- R7: The event status register (0x2C) keeps each bit set until a write with a 1 in that position. Writing 0 to a bit leaves it unchanged. Bits 3 and 4 are never set.
- R8: The event mask (0x28, 5 bits, reads back as written). The irq output is 1 exactly when some status bit and the matching mask bit are both 1. Status bits are set whether masked or not.
- R9: A write issued while busy is 1 does not change any register during the busy window. It takes effect on the first cycle after busy drops.
- R10: After reset, every register reads 0, busy is 0 and irq is 0.
- R11: Reads return data one cycle after rd_en, from the word addressed by addr[5:2]. Unlisted offsets read 0, and an access with addr[1:0] not 00 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per slow reference tick |
| addr | input | 6 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt, masked OR of event status |

## Verification
The bench builds the block with TICKS_PER_MS=2, CORR_PERIOD=2, MS_PER_SEC=4, POST_TICKS=4 and BUSY_LEN=3. At these values a whole second takes ten ticks, and the drift correction changes the counts within a few ticks, so seconds rollover, millisecond wrap and alarm hits are all reached in a few hundred cycles. With a three-cycle busy window the bench can read the busy flag and slip a write into the window from ordinary register tasks. It can then see that the write is held back and then applied.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_EVT  = 5;
    localparam int NUM_SALM = 2;
    localparam int EV_MALM  = 2;

    typedef enum logic [3:0] {
        RG_NONE   = 4'd0,
        RG_BUSY   = 4'd1,
        RG_SEC    = 4'd2,
        RG_SHADOW = 4'd3,
        RG_MSEC   = 4'd4,
        RG_SALM0  = 4'd5,
        RG_SALM1  = 4'd6,
        RG_MALM   = 4'd7,
        RG_MASK   = 4'd10,
        RG_STAT   = 4'd11
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e    sel;
        logic [31:0] data;
    } wr_req_t;

    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int TICKS_PER_MS = 32,
    parameter int CORR_PERIOD  = 8,
    parameter int MS_PER_SEC   = 1000,
    localparam int MS_W        = rtc_pkg::bits_for(MS_PER_SEC),
    localparam int TK_W        = rtc_pkg::bits_for(TICKS_PER_MS + 1),
    localparam int CR_W        = rtc_pkg::bits_for(CORR_PERIOD)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_en,
    input  logic            sec_ld,
    input  logic [31:0]     sec_ld_val,
    output logic [31:0]     sec_o,
    output logic [MS_W-1:0] ms_o,
    output logic            sec_evt_o,
    output logic            ms_evt_o
);
    logic [TK_W-1:0] tk_q;
    logic [CR_W-1:0] cr_q;
    logic            long_ms;
    logic            ms_step;
    logic            ms_wrap;

    always_comb begin
        long_ms = (cr_q == CR_W'(CORR_PERIOD - 1));
        ms_step = tick_en && (tk_q == (long_ms ? TK_W'(TICKS_PER_MS) : TK_W'(TICKS_PER_MS - 1)));
        ms_wrap = ms_step && (ms_o == MS_W'(MS_PER_SEC - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tk_q      <= '0;
            cr_q      <= '0;
            ms_o      <= '0;
            sec_o     <= '0;
            sec_evt_o <= 1'b0;
            ms_evt_o  <= 1'b0;
        end else begin
            if (ms_step) begin
                tk_q <= '0;
                cr_q <= long_ms ? '0 : cr_q + 1'b1;
                ms_o <= ms_wrap ? '0 : ms_o + 1'b1;
            end else if (tick_en) begin
                tk_q <= tk_q + 1'b1;
            end
            if (sec_ld)       sec_o <= sec_ld_val;
            else if (ms_wrap) sec_o <= sec_o + 32'd1;
            sec_evt_o <= sec_ld || ms_wrap;
            ms_evt_o  <= ms_step;
        end
    end

    // R1: a step of the millisecond counter to zero always comes with a seconds step
    a_r1_wrap_bumps_sec: assert property (@(posedge clk) disable iff (rst)
        (ms_evt_o && ms_o == '0) |-> sec_evt_o);

endmodule

// File: rtl/rtc_post.sv
module rtc_post #(
    parameter int POST_TICKS = 8,
    parameter int BUSY_LEN   = 4,
    localparam int PC_W      = rtc_pkg::bits_for(POST_TICKS),
    localparam int BC_W      = rtc_pkg::bits_for(BUSY_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic busy_o,
    output logic copy_o
);
    logic [PC_W-1:0] pc_q;
    logic [BC_W-1:0] bc_q;
    logic            post_due;

    assign post_due = tick_en && (pc_q == PC_W'(POST_TICKS - 1));
    assign copy_o   = busy_o && (bc_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            bc_q   <= '0;
            busy_o <= 1'b0;
        end else begin
            if (post_due)     pc_q <= '0;
            else if (tick_en) pc_q <= pc_q + 1'b1;

            if (busy_o) begin
                if (bc_q == '0) busy_o <= 1'b0;
                else            bc_q   <= bc_q - 1'b1;
            end else if (post_due) begin
                busy_o <= 1'b1;
                bc_q   <= BC_W'(BUSY_LEN - 1);
            end
        end
    end

    // R2: a copy window only opens in answer to a slow tick
    a_r2_busy_from_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(tick_en));

endmodule

// File: rtl/rtc_events.sv
module rtc_events #(
    parameter int MS_W = 10
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [31:0]                           sec_i,
    input  logic                                  sec_evt_i,
    input  logic [MS_W-1:0]                       ms_i,
    input  logic                                  ms_evt_i,
    input  logic [rtc_pkg::NUM_SALM-1:0][31:0]    cmp_sec_i,
    input  logic [MS_W-1:0]                       cmp_ms_i,
    input  logic [rtc_pkg::NUM_EVT-1:0]           mask_i,
    input  logic                                  clr_we_i,
    input  logic [rtc_pkg::NUM_EVT-1:0]           clr_i,
    output logic [rtc_pkg::NUM_EVT-1:0]           stat_o,
    output logic                                  irq_o
);
    import rtc_pkg::*;

    logic [NUM_EVT-1:0] fire;
    logic [NUM_EVT-1:0] clr_eff;

    for (genvar g = 0; g < NUM_SALM; g++) begin : g_salm
        assign fire[g] = sec_evt_i && (cmp_sec_i[g] != '0) && (sec_i == cmp_sec_i[g]);

        // R5: a seconds alarm with compare value zero never raises its bit
        a_r5_zero_never: assert property (@(posedge clk) disable iff (rst)
            $rose(stat_o[g]) |-> ($past(cmp_sec_i[g]) != '0));
    end

    assign fire[EV_MALM] = ms_evt_i && (cmp_ms_i != '0) && (ms_i == cmp_ms_i);
    assign fire[NUM_EVT-1:EV_MALM+1] = '0;
    assign clr_eff = clr_we_i ? clr_i : '0;
    assign irq_o   = |(stat_o & mask_i);

    always_ff @(posedge clk) begin
        if (rst) stat_o <= '0;
        else     stat_o <= (stat_o & ~clr_eff) | fire;
    end

    // R7: a status bit only drops after a clearing write
    a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat_o) & ~stat_o)) |-> $past(clr_we_i));

endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer #(
    parameter int TICKS_PER_MS = 32,
    parameter int CORR_PERIOD  = 8,
    parameter int MS_PER_SEC   = 1000,
    parameter int POST_TICKS   = 8,
    parameter int BUSY_LEN     = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic [5:0]  addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        irq
);
    import rtc_pkg::*;

    localparam int MS_W = bits_for(MS_PER_SEC);

    logic                         busy, copy;
    logic [31:0]                  sec_run;
    logic [MS_W-1:0]              ms_run;
    logic                         sec_evt, ms_evt;
    logic [31:0]                  sec_vis, shadow_q;
    logic [MS_W-1:0]              ms_vis, cmp_ms_q;
    logic [NUM_SALM-1:0][31:0]    cmp_sec_q;
    logic [NUM_EVT-1:0]           mask_q, stat;
    logic                         word_ok, wr_go, rd_go;
    wr_req_t                      req, pend_q, app;
    logic                         pend_v, app_v;
    logic                         sec_ld, clr_we;
    reg_sel_e                     rd_sel;

    assign word_ok = (addr[1:0] == 2'b00);
    assign wr_go   = wr_en && word_ok;
    assign rd_go   = rd_en && word_ok;
    assign rd_sel  = reg_sel_e'(addr[5:2]);
    assign req     = '{sel: reg_sel_e'(addr[5:2]), data: wr_data};

    always_comb begin
        app_v = 1'b0;
        app   = req;
        if (!busy) begin
            if (pend_v) begin
                app_v = 1'b1;
                app   = pend_q;
            end else if (wr_go) begin
                app_v = 1'b1;
            end
        end
        sec_ld = app_v && (app.sel == RG_SEC);
        clr_we = app_v && (app.sel == RG_STAT);
    end

    rtc_timebase #(
        .TICKS_PER_MS(TICKS_PER_MS),
        .CORR_PERIOD (CORR_PERIOD),
        .MS_PER_SEC  (MS_PER_SEC)
    ) u_tb (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .sec_ld    (sec_ld),
        .sec_ld_val(app.data),
        .sec_o     (sec_run),
        .ms_o      (ms_run),
        .sec_evt_o (sec_evt),
        .ms_evt_o  (ms_evt)
    );

    rtc_post #(
        .POST_TICKS(POST_TICKS),
        .BUSY_LEN  (BUSY_LEN)
    ) u_post (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .busy_o (busy),
        .copy_o (copy)
    );

    rtc_events #(
        .MS_W(MS_W)
    ) u_evt (
        .clk      (clk),
        .rst      (rst),
        .sec_i    (sec_run),
        .sec_evt_i(sec_evt),
        .ms_i     (ms_run),
        .ms_evt_i (ms_evt),
        .cmp_sec_i(cmp_sec_q),
        .cmp_ms_i (cmp_ms_q),
        .mask_i   (mask_q),
        .clr_we_i (clr_we),
        .clr_i    (app.data[NUM_EVT-1:0]),
        .stat_o   (stat),
        .irq_o    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_q    <= '{sel: RG_NONE, data: '0};
            sec_vis   <= '0;
            ms_vis    <= '0;
            shadow_q  <= '0;
            cmp_sec_q <= '0;
            cmp_ms_q  <= '0;
            mask_q    <= '0;
            rd_data   <= '0;
        end else begin
            if (wr_go && (busy || pend_v)) begin
                pend_v <= 1'b1;
                pend_q <= req;
            end else if (app_v && pend_v) begin
                pend_v <= 1'b0;
            end

            if (copy) begin
                sec_vis <= sec_run;
                ms_vis  <= ms_run;
            end

            if (app_v) begin
                case (app.sel)
                    RG_SEC:   sec_vis      <= app.data;
                    RG_SALM0: cmp_sec_q[0] <= app.data;
                    RG_SALM1: cmp_sec_q[1] <= app.data;
                    RG_MALM:  cmp_ms_q     <= app.data[MS_W-1:0];
                    RG_MASK:  mask_q       <= app.data[NUM_EVT-1:0];
                    default:  ;
                endcase
            end

            if (rd_go) begin
                if (rd_sel == RG_MSEC) shadow_q <= sec_vis;
                case (rd_sel)
                    RG_BUSY:   rd_data <= {31'd0, busy};
                    RG_SEC:    rd_data <= sec_vis;
                    RG_SHADOW: rd_data <= shadow_q;
                    RG_MSEC:   rd_data <= 32'(ms_vis);
                    RG_SALM0:  rd_data <= cmp_sec_q[0];
                    RG_SALM1:  rd_data <= cmp_sec_q[1];
                    RG_MALM:   rd_data <= 32'(cmp_ms_q);
                    RG_MASK:   rd_data <= 32'(mask_q);
                    RG_STAT:   rd_data <= 32'(stat);
                    default:   rd_data <= '0;
                endcase
            end
        end
    end

    // R9: the seconds counter is never loaded inside a copy window
    a_r9_no_load_in_busy: assert property (@(posedge clk) disable iff (rst)
        sec_ld |-> !busy);

    // R9: a held write drains once the window closes and nothing new arrives
    a_r9_hold_drains: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !busy && !wr_go) |=> !pend_v);

    // R2: visible milliseconds change only as a copy window closes
    a_r2_copy_at_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(ms_vis) |-> $fell(busy));

    // R3: a milliseconds read captures the visible seconds of that cycle
    a_r3_shadow_capture: assert property (@(posedge clk) disable iff (rst)
        (rd_go && rd_sel == RG_MSEC) |=> (shadow_q == $past(sec_vis)));

endmodule

// File: tb/tb_rtc_shadow_timer.sv
`timescale 1ns/1ps
module tb_rtc_shadow_timer;

    localparam logic [5:0] A_BUSY = 6'h04, A_SEC = 6'h08, A_SHD = 6'h0C, A_MS = 6'h10,
                           A_AL0 = 6'h14, A_AL1 = 6'h18, A_MAL = 6'h1C,
                           A_MASK = 6'h28, A_STAT = 6'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    rtc_shadow_timer #(
        .TICKS_PER_MS(2), .CORR_PERIOD(2), .MS_PER_SEC(4),
        .POST_TICKS(4), .BUSY_LEN(3)
    ) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rd(A_BUSY, v); chk("R10 busy", v, 0);
        rd(A_SEC, v);  chk("R10 sec", v, 0);
        rd(A_MS, v);   chk("R10 ms", v, 0);
        rd(A_AL0, v);  chk("R10 alarm0", v, 0);
        rd(A_MASK, v); chk("R10 mask", v, 0);
        rd(A_STAT, v); chk("R10 status", v, 0);
        chk("R10 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_timebase;
        ticks(12);
        rd(A_MS, v);  chk("R1 ms after 12 ticks", v, 1);
        rd(A_SHD, v); chk("R3 shadow pairs with ms", v, 1);
        ticks(8);
        rd(A_MS, v);  chk("R1 ms wrap", v, 0);
        rd(A_SEC, v); chk("R2 posted sec", v, 2);
        rd(A_STAT, v); chk("R5 zero compare silent", v, 0);
    endtask

    task automatic t_busy_hold;
        ticks(3);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0; addr = A_BUSY; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
        chk("R2 busy during copy", v, 1);
        addr = A_AL1; wr_data = 32'd7; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; addr = A_AL1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
        chk("R9 write held while busy", v, 0);
        repeat (3) @(negedge clk);
        rd(A_AL1, v); chk("R9 held write applied", v, 7);
        rd(A_BUSY, v); chk("R2 busy cleared", v, 0);
        rd(A_MS, v);  chk("R1 corrected ms at post", v, 1);
        rd(A_ZERO_OFF(), v); chk("R11 unlisted offset", v, 0);
    endtask

    function automatic logic [5:0] A_ZERO_OFF();
        return 6'h20;
    endfunction

    task automatic t_sec_write_alarm;
        wr(A_SEC, 32'd100);
        rd(A_SEC, v); chk("R4 seconds load visible", v, 100);
        wr(A_AL0, 32'd101);
        wr(A_MASK, 32'd1);
        ticks(8);
        rd(A_SEC, v); chk("R4 counter runs from loaded value", v, 101);
        rd(A_MS, v);  chk("R1 ms after rollover", v, 1);
        rd(A_STAT, v); chk("R5 alarm0 fired", v, 1);
        chk("R8 irq for masked-in alarm", {31'd0, irq}, 1);
        wr(6'h2D, 32'd1);
        rd(A_STAT, v); chk("R11 misaligned write ignored", v, 1);
    endtask

    task automatic t_shadow;
        rd(A_MS, v);
        wr(A_SEC, 32'd500);
        rd(A_SHD, v); chk("R3 shadow keeps captured value", v, 101);
        rd(A_SEC, v); chk("R4 new seconds visible", v, 500);
    endtask

    task automatic t_w1c_mask;
        wr(A_STAT, 32'd0);
        rd(A_STAT, v); chk("R7 zero write keeps bit", v, 1);
        wr(A_STAT, 32'd1);
        rd(A_STAT, v); chk("R7 one clears bit", v, 0);
        chk("R8 irq low after clear", {31'd0, irq}, 0);
        wr(A_AL1, 32'd501);
        wr(A_MAL, 32'd2);
        ticks(8);
        rd(A_STAT, v); chk("R6 ms alarm and R5 alarm1 set", v, 6);
        chk("R8 masked events no irq", {31'd0, irq}, 0);
        wr(A_MASK, 32'd2);
        @(negedge clk); chk("R8 irq after unmask", {31'd0, irq}, 1);
        rd(A_MASK, v); chk("R8 mask readback", v, 2);
        wr(A_STAT, 32'd2);
        rd(A_STAT, v); chk("R7 partial clear", v, 4);
        wr(A_STAT, 32'h18);
        rd(A_STAT, v); chk("R7 countdown bits inert", v, 4);
        wr(A_STAT, 32'd4);
        rd(A_STAT, v); chk("R7 cleared", v, 0);
    endtask

    task automatic t_zero_alarm;
        wr(A_AL0, 32'd0);
        wr(A_SEC, 32'd0);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); chk("R5 compare zero never fires", v, 0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_timebase();
        t_busy_hold();
        t_sec_write_alarm();
        t_shadow();
        t_w1c_mask();
        t_zero_alarm();
        finish_run();
    end

endmodule